// File: doc/BRIEF.md
# DMA Channel Address-Adjust Instruction Unit

This unit executes the two address-adjust instructions of a DMA channel thread. It takes instructions one byte per cycle through a valid/ready handshake. Each instruction is three bytes long, and the unit assembles them into one operation. It then adds a signed 16-bit step to one of two 32-bit address registers, the source or the destination, and writes the result back in place. Because the sum wraps modulo 2^32, one adder can move an address forward by up to 65535 bytes or back by up to 65536 bytes. This covers row strides in two-dimensional transfers and walks through memory in descending order.

A thread-type input says whether the stream belongs to a channel thread or to a manager thread. The unit rejects an instruction that is issued in the wrong thread, and it also rejects an unknown opcode byte. Either case gives a one-cycle fault pulse with a cause code. A synchronous load port presets both address registers. Both registers are visible at the outputs at all times.

Top module: `dma_addr_adjust`

## Requirements
- R1: After reset, `src_addr` and `dst_addr` are zero, `done` and `fault` are low, `fault_cause` is 0 and `in_ready` is high.
- R2: The opcode bytes 0x54 and 0x56 are the add form. The unit zero-extends the 16-bit immediate and adds it to the selected register.
- R3: The add keeps only the low 32 bits of the sum, so a result above 0xFFFFFFFF wraps around past zero.
- R4: The opcode bytes 0x5C and 0x5E are the negative form. The unit fills the upper 16 bits of the immediate with ones before the add, so the register loses 65536 minus the immediate. An immediate of 0x0000 subtracts 65536 and 0xFFFF subtracts 1.
- R5: Opcode bit 1 chooses the register: 0 selects the source register and 1 selects the destination register. The register that is not selected keeps its value.
- R6: An instruction arrives in this byte order: the opcode byte, then immediate bits [7:0], then immediate bits [15:8].
- R7: Any first byte other than the four opcodes is undefined. In the cycle after that byte is accepted, `fault` is high and `fault_cause` is 1. Both registers are unchanged, and no further bytes are consumed for that instruction.
- R8: A valid opcode that is accepted while `is_manager` is high raises `fault` with `fault_cause` 2 in the next cycle. The unit then discards the two following bytes and leaves both registers unchanged. An undefined opcode reports cause 1 even in a manager thread.
- R9: `done` is high for exactly one cycle, the cycle after the last immediate byte is accepted. The new register value is visible in the cycle after that. A `fault` pulse lasts one cycle.
- R10: `in_ready` is low only during the write-back cycle, which is the cycle in which `done` is high.
- R11: When `load_en` is high at a clock edge, `src_addr` takes `load_src` and `dst_addr` takes `load_dst`. If the load falls in the write-back cycle, the load wins and the adjust result is dropped, but `done` still pulses.
- R12: A byte is consumed only at an edge where `in_valid` and `in_ready` are both high. Idle cycles between the bytes of one instruction do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit can accept a byte |
| is_manager | input | 1 | 1 = stream comes from a manager thread, 0 = channel thread |
| load_en | input | 1 | Preset both address registers |
| load_src | input | 32 | Preset value for the source register |
| load_dst | input | 32 | Preset value for the destination register |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| done | output | 1 | One-cycle pulse during write-back |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | 1 = undefined opcode, 2 = wrong thread, 0 = no fault |

## Verification
The preset load and the instruction write-back can hit a register at the same edge. The bench provokes this by raising `load_en` exactly in the cycle where `done` is high. It expects both registers to hold the loaded values and the adjust result to be gone. A second overlap is a byte that is held valid during write-back. The bench checks that the byte is not taken until `in_ready` returns, and that it then starts the next instruction correctly. Random streams mix legal, undefined and wrong-thread instructions, idle gaps and stray loads, and a bench model predicts every register value.

// File: rtl/dma_aa_pkg.sv
package dma_aa_pkg;

  typedef enum logic [1:0] {
    ST_OPCODE = 2'd0,
    ST_IMM    = 2'd1,
    ST_SKIP   = 2'd2,
    ST_WB     = 2'd3
  } aa_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_UNDEF  = 2'd1,
    CAUSE_THREAD = 2'd2
  } aa_cause_e;

  typedef struct packed {
    logic legal;
    logic negate;
    logic dst_sel;
  } aa_dec_t;

  // Fixed opcode pattern 0101_n1r0: n = negative form, r = register select
  localparam logic [3:0] OPC_HIGH_NIBBLE = 4'b0101;

endpackage

// File: rtl/dma_aa_decode.sv
module dma_aa_decode
  import dma_aa_pkg::*;
(
  input  logic [7:0] opcode,
  output aa_dec_t    dec
);

  always_comb begin
    dec.legal   = (opcode[7:4] == OPC_HIGH_NIBBLE) && opcode[2] && !opcode[0];
    dec.negate  = opcode[3];
    dec.dst_sel = opcode[1];
  end

endmodule

// File: rtl/dma_aa_seq.sv
module dma_aa_seq
  import dma_aa_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              is_manager,
  input  aa_dec_t           dec,
  output logic              wb_en,
  output logic              wb_neg,
  output logic              wb_dst,
  output logic [IMM_W-1:0]  wb_imm,
  output logic              fault,
  output logic [1:0]        fault_cause
);

  localparam int IMM_BYTES = IMM_W / BYTE_W;
  localparam int CNT_W     = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IMM_BYTES - 1);

  aa_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             neg_q, neg_d;
  logic             dst_q, dst_d;
  logic             fault_q, fault_d;
  aa_cause_e        cause_q, cause_d;
  logic             take;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    neg_d    = neg_q;
    dst_d    = dst_q;
    fault_d  = 1'b0;
    cause_d  = CAUSE_NONE;
    in_ready = (state_q != ST_WB);
    take     = in_valid && in_ready;
    case (state_q)
      ST_OPCODE: begin
        if (take) begin
          if (!dec.legal) begin
            fault_d = 1'b1;
            cause_d = CAUSE_UNDEF;
          end else if (is_manager) begin
            fault_d = 1'b1;
            cause_d = CAUSE_THREAD;
            state_d = ST_SKIP;
            cnt_d   = '0;
          end else begin
            neg_d   = dec.negate;
            dst_d   = dec.dst_sel;
            state_d = ST_IMM;
            cnt_d   = '0;
          end
        end
      end
      ST_IMM: begin
        if (take) begin
          if (cnt_q == CNT_LAST) state_d = ST_WB;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_SKIP: begin
        if (take) begin
          if (cnt_q == CNT_LAST) state_d = ST_OPCODE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_WB:   state_d = ST_OPCODE;
      default: state_d = ST_OPCODE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;
      cnt_q   <= '0;
      neg_q   <= 1'b0;
      dst_q   <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      neg_q   <= neg_d;
      dst_q   <= dst_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end

  // One capture lane per immediate byte, low byte first
  for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
    logic lane_en;
    assign lane_en = take && (state_q == ST_IMM) && (cnt_q == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wb_imm[g*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_en) begin
        wb_imm[g*BYTE_W +: BYTE_W] <= in_byte;
      end
    end
  end

  assign wb_en       = (state_q == ST_WB);
  assign wb_neg      = neg_q;
  assign wb_dst      = dst_q;
  assign fault       = fault_q;
  assign fault_cause = cause_q;

endmodule

// File: rtl/dma_aa_addr.sv
module dma_aa_addr #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic              wb_en,
  input  logic              wb_neg,
  input  logic              wb_dst,
  input  logic [IMM_W-1:0]  wb_imm,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] operand, base, sum;
  logic [ADDR_W-1:0] src_d, dst_d;
  logic              src_en, dst_en;

  always_comb begin
    operand = {{EXT_W{wb_neg}}, wb_imm};
    base    = wb_dst ? dst_q : src_q;
    sum     = base + operand;
    src_en  = load_en || (wb_en && !wb_dst);
    dst_en  = load_en || (wb_en && wb_dst);
    src_d   = load_en ? load_src : sum;
    dst_d   = load_en ? load_dst : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (dst_en) dst_q <= dst_d;
    end
  end

endmodule

// File: rtl/dma_addr_adjust.sv
module dma_addr_adjust
  import dma_aa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  logic              is_manager,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_cause
);

  aa_dec_t            dec;
  logic               wb_en, wb_neg, wb_dst;
  logic [IMM_W-1:0]   wb_imm;

  dma_aa_decode u_decode (
    .opcode (in_byte[7:0]),
    .dec    (dec)
  );

  dma_aa_seq #(.BYTE_W(BYTE_W), .IMM_W(IMM_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_ready    (in_ready),
    .is_manager  (is_manager),
    .dec         (dec),
    .wb_en       (wb_en),
    .wb_neg      (wb_neg),
    .wb_dst      (wb_dst),
    .wb_imm      (wb_imm),
    .fault       (fault),
    .fault_cause (fault_cause)
  );

  dma_aa_addr #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_src (load_src),
    .load_dst (load_dst),
    .wb_en    (wb_en),
    .wb_neg   (wb_neg),
    .wb_dst   (wb_dst),
    .wb_imm   (wb_imm),
    .src_q    (src_addr),
    .dst_q    (dst_addr)
  );

  assign done = wb_en;

endmodule

// File: rtl/dma_aa_chk.sv
module dma_aa_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_src,
  input logic [ADDR_W-1:0] load_dst,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              done,
  input logic              fault
);

  assert_ready_low_only_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  assert_fault_keeps_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(rst_n) && !$past(load_en)) |-> ($stable(src_addr) && $stable(dst_addr)));

  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_en)) |->
      (src_addr == $past(load_src) && dst_addr == $past(load_dst)));

  assert_one_reg_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_en) |=> ((src_addr == $past(src_addr)) || (dst_addr == $past(dst_addr))));

  assert_write_only_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(load_en) && !$past(done)) |->
      ($stable(src_addr) && $stable(dst_addr)));

  assert_no_fault_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && done));

endmodule

bind dma_addr_adjust dma_aa_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .load_en  (load_en),
  .load_src (load_src),
  .load_dst (load_dst),
  .src_addr (src_addr),
  .dst_addr (dst_addr),
  .done     (done),
  .fault    (fault)
);

// File: tb/dma_addr_adjust_bench.sv
`timescale 1ns/1ps
module dma_addr_adjust_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic        is_manager;
  logic        load_en;
  logic [31:0] load_src, load_dst;
  logic [31:0] src_addr, dst_addr;
  logic        done, fault;
  logic [1:0]  fault_cause;

  int n_checks = 0;
  int n_fail   = 0;
  logic finished = 1'b0;
  logic [31:0] m_src, m_dst;
  int seed_dummy;

  dma_addr_adjust u_dma_addr_adjust (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .is_manager(is_manager), .load_en(load_en),
    .load_src(load_src), .load_dst(load_dst), .src_addr(src_addr),
    .dst_addr(dst_addr), .done(done), .fault(fault), .fault_cause(fault_cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic is_legal(input logic [7:0] b);
    return (b == 8'h54) || (b == 8'h56) || (b == 8'h5C) || (b == 8'h5E);
  endfunction

  function automatic logic [31:0] adjusted(input logic [31:0] r, input logic neg,
                                           input logic [15:0] imm);
    logic [31:0] step;
    step = neg ? (32'hFFFF0000 | {16'h0, imm}) : {16'h0, imm};
    return r + step;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk({req, " src"}, src_addr, m_src);
    chk({req, " dst"}, dst_addr, m_dst);
  endtask

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic send_byte(input logic [7:0] b, input int gap);
    for (int i = 0; i < gap; i++) @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = $urandom;
  endtask

  task automatic do_load(input logic [31:0] s, input logic [31:0] d);
    load_en = 1'b1; load_src = s; load_dst = d;
    @(negedge clk);
    load_en = 1'b0;
    m_src = s; m_dst = d;
    chk_regs("R11 load");
  endtask

  // Full legal instruction in a channel thread
  task automatic run_legal(input logic [7:0] op, input logic [15:0] imm,
                           input int gap, input logic collide,
                           input logic [31:0] ls, input logic [31:0] ld);
    is_manager = 1'b0;
    send_byte(op, gap);
    chk("R9 no fault on legal", {31'b0, fault}, 32'd0);
    send_byte(imm[7:0], gap);
    send_byte(imm[15:8], gap);
    chk("R9 done in write-back", {31'b0, done}, 32'd1);
    chk("R10 ready low in write-back", {31'b0, in_ready}, 32'd0);
    chk_regs("R9 regs old during write-back");
    if (collide) begin
      load_en = 1'b1; load_src = ls; load_dst = ld;
    end
    @(negedge clk);
    load_en = 1'b0;
    if (collide) begin
      m_src = ls; m_dst = ld;
    end else if (op[1]) begin
      m_dst = adjusted(m_dst, op[3], imm);
    end else begin
      m_src = adjusted(m_src, op[3], imm);
    end
    chk_regs(op[3] ? "R4 R5 R6 negative form" : "R2 R3 R5 R6 add form");
    chk("R9 done single", {31'b0, done}, 32'd0);
    chk("R10 ready back", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic run_undef(input logic [7:0] op, input logic mgr);
    is_manager = mgr;
    send_byte(op, 0);
    chk("R7 fault", {31'b0, fault}, 32'd1);
    chk("R7 cause undefined", {30'b0, fault_cause}, 32'd1);
    chk_regs("R7 regs unchanged");
    @(negedge clk);
    chk("R9 fault single cycle", {31'b0, fault}, 32'd0);
    is_manager = 1'b0;
  endtask

  task automatic run_manager(input logic [7:0] op, input logic [7:0] b1,
                             input logic [7:0] b2);
    is_manager = 1'b1;
    send_byte(op, 0);
    chk("R8 fault", {31'b0, fault}, 32'd1);
    chk("R8 cause wrong thread", {30'b0, fault_cause}, 32'd2);
    is_manager = 1'b0;
    send_byte(b1, 0);
    chk("R9 fault single cycle", {31'b0, fault}, 32'd0);
    send_byte(b2, 0);
    chk("R8 no done on discard", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk_regs("R8 regs unchanged");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [4];
    ops[0] = 8'h54; ops[1] = 8'h56; ops[2] = 8'h5C; ops[3] = 8'h5E;
    seed_dummy = $urandom(32'h1D2C3B4A);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h0; is_manager = 1'b0;
    load_en = 1'b0; load_src = '0; load_dst = '0;
    m_src = '0; m_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_regs("R1 reset");
    chk("R1 ready", {31'b0, in_ready}, 32'd1);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 fault", {31'b0, fault}, 32'd0);
    chk("R1 cause", {30'b0, fault_cause}, 32'd0);

    // R2 basic add on source, R6 byte order with distinct bytes
    do_load(32'h0000_1000, 32'h0000_2000);
    run_legal(8'h54, 16'h1234, 0, 1'b0, 0, 0);
    chk("R6 src byte order", src_addr, 32'h0000_2234);
    run_legal(8'h56, 16'hABCD, 0, 1'b0, 0, 0);
    chk("R5 dst add", dst_addr, 32'h0000_CBCD);
    // R3 wrap
    do_load(32'hFFFF_FFF0, 32'hFFFF_0000);
    run_legal(8'h54, 16'h0020, 0, 1'b0, 0, 0);
    chk("R3 wrap src", src_addr, 32'h0000_0010);
    run_legal(8'h56, 16'hFFFF, 0, 1'b0, 0, 0);
    chk("R3 wrap dst", dst_addr, 32'hFFFF_FFFF);
    // R4 extremes
    do_load(32'h0001_0000, 32'h0000_0005);
    run_legal(8'h5C, 16'h0000, 0, 1'b0, 0, 0);
    chk("R4 subtract 65536", src_addr, 32'h0000_0000);
    run_legal(8'h5E, 16'hFFFF, 0, 1'b0, 0, 0);
    chk("R4 subtract 1", dst_addr, 32'h0000_0004);
    run_legal(8'h5E, 16'hFFF0, 0, 1'b0, 0, 0);
    chk("R4 R3 wrap below zero", dst_addr, 32'hFFFF_FFF4);
    // R7 undefined, also in manager thread
    run_undef(8'h55, 1'b0);
    run_undef(8'h00, 1'b1);
    run_undef(8'hD4, 1'b0);
    // R8 wrong thread, discarded bytes look like opcodes
    run_manager(8'h5E, 8'h54, 8'h56);
    // R12 gaps between bytes
    run_legal(8'h54, 16'h0101, 2, 1'b0, 0, 0);
    // R11 load colliding with write-back
    run_legal(8'h56, 16'h0FFF, 0, 1'b1, 32'hA5A5_0000, 32'h5A5A_0000);

    // R10 byte held valid through write-back
    is_manager = 1'b0;
    send_byte(8'h54, 0);
    send_byte(8'h10, 0);
    send_byte(8'h00, 0);
    in_valid = 1'b1; in_byte = 8'h56;
    chk("R10 ready low with byte pending", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    m_src = adjusted(m_src, 1'b0, 16'h0010);
    chk_regs("R10 write-back completed");
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    send_byte(8'h22, 0);
    send_byte(8'h00, 0);
    chk("R10 held byte taken as opcode", {31'b0, done}, 32'd1);
    @(negedge clk);
    m_dst = adjusted(m_dst, 1'b0, 16'h0022);
    chk_regs("R10 held instruction result");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int kind;
      kind = $urandom % 10;
      if (kind == 0) begin
        logic [7:0] b;
        b = $urandom;
        if (is_legal(b)) b = 8'hFF;
        run_undef(b, ($urandom % 2) == 0);
      end else if (kind == 1) begin
        run_manager(ops[$urandom % 4], $urandom, $urandom);
      end else if (kind == 2) begin
        do_load($urandom, $urandom);
      end else begin
        run_legal(ops[$urandom % 4], $urandom, $urandom % 3,
                  ($urandom % 8) == 0, $urandom, $urandom);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule